// File: doc/BRIEF.md
# CPU Quadrature Clock Generator with Turbo Rate

This block produces the two quadrature clocks (E and its leading partner Q) that a 6809E-class processor needs, deriving them from a fast master timing reference. The master reference reaches the block as a one-cycle `tick` pulse for every master half-cycle. All waveform timing is counted in these ticks.

Three rates exist. Slow is the rate after reset. Normal is selected when the host writes to a fixed address, and a write to a neighbouring address goes back to slow. The data value of the write is irrelevant. Turbo runs only while normal is selected and the speed strap reads high. An open strap is pulled high and so requests turbo. A grounded strap keeps the block at normal. In turbo each CPU cycle lasts six ticks and E and Q are each high for three ticks, which is one and a half master cycles. The rate in use is changed only where a complete E cycle ends, so no shortened pulse ever leaves the block.

Two indicators are provided. `fast_ind` mirrors the selected normal speed. `turbo_ind` shows that turbo-length cycles are being produced at that moment.

Top module: `qclk_gen`

## Requirements
- R1: While and after reset, E, Q, `fast_ind` and `turbo_ind` are low, and the first cycle runs at the slow rate, counted from the first tick after reset.
- R2: A write (`wr` high) with `addr` = 16'hFFD9 sets `fast_ind` at the next clock edge.
- R3: A write with `addr` = 16'hFFD8 clears `fast_ind`. A write to any other address leaves `fast_ind` unchanged.
- R4: At the slow rate, a cycle lasts 32 ticks, E is high for the last 16 ticks of the cycle, and Q rises 8 ticks before E.
- R5: At the normal rate, a cycle lasts 16 ticks, E is high for the last 8 ticks, and Q rises 4 ticks before E.
- R6: At the turbo rate, a cycle lasts 6 ticks, E is high for the last 3 ticks, and Q is high for 3 ticks beginning 1 tick before E. Turbo is chosen for a new cycle only if `fast_ind` is set and `turbo_strap` is 1.
- R7: With `turbo_strap` = 0, a new cycle under normal speed selection runs at the normal rate. When normal speed is not selected, the strap has no effect.
- R8: The rate of a cycle is fixed at the clock edge where the previous E falls. `turbo_ind` is high exactly while a turbo cycle runs.
- R9: E and Q change only at clock edges where `tick` is high.
- R10: In every rate, Q is already high when E rises and Q is already low when E falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per master half-cycle |
| addr | input | 16 | CPU address |
| wr | input | 1 | CPU write strobe |
| turbo_strap | input | 1 | Speed strap, 1 (open) requests turbo |
| e_clk | output | 1 | E clock to the CPU |
| q_clk | output | 1 | Q clock to the CPU, leads E |
| fast_ind | output | 1 | Normal speed selected |
| turbo_ind | output | 1 | Turbo cycles being generated |

## Verification
On every cycle the assertions check three things. E and Q hold still on edges without a tick. Q rises before E and falls before it. The running rate changes only together with a falling E, and turbo starts only when normal speed and the strap both allowed it. The exact tick counts of each rate, the absence of runt pulses across random mode switches, and the decoding of the speed addresses can only be seen in the bench. The bench models the cycle position tick by tick and compares both clocks and both indicators on every clock.

// File: rtl/qclk_pkg.sv
package qclk_pkg;
   typedef enum logic [1:0] {
      RATE_SLOW  = 2'd0,
      RATE_NORM  = 2'd1,
      RATE_TURBO = 2'd2
   } rate_e;
endpackage

// File: rtl/qclk_speed_reg.sv
module qclk_speed_reg #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] FAST_ADDR = 16'hFFD9,
   parameter logic [15:0] SLOW_ADDR = 16'hFFD8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              fast_sel
);
   localparam logic [ADDR_W-1:0] FAST_A = ADDR_W'(FAST_ADDR);
   localparam logic [ADDR_W-1:0] SLOW_A = ADDR_W'(SLOW_ADDR);

   if (FAST_A == SLOW_A) begin : g_addr_clash
      $error("speed addresses must differ");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     fast_sel <= 1'b0;
      else if (wr && addr == FAST_A)  fast_sel <= 1'b1;
      else if (wr && addr == SLOW_A)  fast_sel <= 1'b0;
   end

   // R3
   slow_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == SLOW_A) |=> !fast_sel);
endmodule

// File: rtl/qclk_rate_sel.sv
module qclk_rate_sel
   import qclk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fast_sel,
   input  logic  turbo_strap,
   input  logic  cycle_end,
   output rate_e rate
);
   rate_e rate_req;

   always_comb begin
      if (!fast_sel)        rate_req = RATE_SLOW;
      else if (turbo_strap) rate_req = RATE_TURBO;
      else                  rate_req = RATE_NORM;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rate <= RATE_SLOW;
      else if (cycle_end) rate <= rate_req;
   end
endmodule

// File: rtl/qclk_phase_gen.sv
module qclk_phase_gen
   import qclk_pkg::*;
#(
   parameter int SLOW_PER   = 32,
   parameter int SLOW_HI    = 16,
   parameter int SLOW_LEAD  = 8,
   parameter int NORM_PER   = 16,
   parameter int NORM_HI    = 8,
   parameter int NORM_LEAD  = 4,
   parameter int TURBO_PER  = 6,
   parameter int TURBO_HI   = 3,
   parameter int TURBO_LEAD = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  rate_e rate,
   output logic  cycle_end,
   output logic  e_clk,
   output logic  q_clk
);
   localparam int PER_A  [3] = '{SLOW_PER,  NORM_PER,  TURBO_PER};
   localparam int HI_A   [3] = '{SLOW_HI,   NORM_HI,   TURBO_HI};
   localparam int LEAD_A [3] = '{SLOW_LEAD, NORM_LEAD, TURBO_LEAD};
   localparam int MAX_PER = (SLOW_PER > NORM_PER)
                            ? ((SLOW_PER > TURBO_PER) ? SLOW_PER : TURBO_PER)
                            : ((NORM_PER > TURBO_PER) ? NORM_PER : TURBO_PER);
   localparam int PH_W = $clog2(MAX_PER);

   for (genvar m = 0; m < 3; m++) begin : g_timing_chk
      if (LEAD_A[m] < 1 || LEAD_A[m] >= HI_A[m] || HI_A[m] + LEAD_A[m] >= PER_A[m]) begin : g_bad
         $error("rate timing out of range");
      end
   end

   logic [PH_W-1:0] phase, nxt, last_ph, e_on, q_on, q_off;

   always_comb begin
      unique case (rate)
         RATE_NORM: begin
            last_ph = PH_W'(NORM_PER - 1);
            e_on    = PH_W'(NORM_PER - NORM_HI);
            q_on    = PH_W'(NORM_PER - NORM_HI - NORM_LEAD);
            q_off   = PH_W'(NORM_PER - NORM_LEAD);
         end
         RATE_TURBO: begin
            last_ph = PH_W'(TURBO_PER - 1);
            e_on    = PH_W'(TURBO_PER - TURBO_HI);
            q_on    = PH_W'(TURBO_PER - TURBO_HI - TURBO_LEAD);
            q_off   = PH_W'(TURBO_PER - TURBO_LEAD);
         end
         default: begin
            last_ph = PH_W'(SLOW_PER - 1);
            e_on    = PH_W'(SLOW_PER - SLOW_HI);
            q_on    = PH_W'(SLOW_PER - SLOW_HI - SLOW_LEAD);
            q_off   = PH_W'(SLOW_PER - SLOW_LEAD);
         end
      endcase
      cycle_end = tick && (phase == last_ph);
      nxt       = cycle_end ? '0 : phase + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
         e_clk <= 1'b0;
         q_clk <= 1'b0;
      end else if (tick) begin
         phase <= nxt;
         e_clk <= (nxt >= e_on);
         q_clk <= (nxt >= q_on) && (nxt < q_off);
      end
   end

   // R9
   clocks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(e_clk) && $stable(q_clk)));
   // R10
   q_leads_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_clk) |-> q_clk);
   // R10
   q_leads_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(e_clk) |-> !q_clk);
endmodule

// File: rtl/qclk_gen.sv
module qclk_gen
   import qclk_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] FAST_ADDR  = 16'hFFD9,
   parameter logic [15:0] SLOW_ADDR  = 16'hFFD8,
   parameter int          SLOW_PER   = 32,
   parameter int          SLOW_HI    = 16,
   parameter int          SLOW_LEAD  = 8,
   parameter int          NORM_PER   = 16,
   parameter int          NORM_HI    = 8,
   parameter int          NORM_LEAD  = 4,
   parameter int          TURBO_PER  = 6,
   parameter int          TURBO_HI   = 3,
   parameter int          TURBO_LEAD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              turbo_strap,
   output logic              e_clk,
   output logic              q_clk,
   output logic              fast_ind,
   output logic              turbo_ind
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_width_chk
      $error("ADDR_W must be 1..16");
   end

   logic  fast_sel;
   logic  cycle_end;
   rate_e rate;

   qclk_speed_reg #(
      .ADDR_W   (ADDR_W),
      .FAST_ADDR(FAST_ADDR),
      .SLOW_ADDR(SLOW_ADDR)
   ) i_speed_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr      (wr),
      .fast_sel(fast_sel)
   );

   qclk_rate_sel i_rate_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_sel   (fast_sel),
      .turbo_strap(turbo_strap),
      .cycle_end  (cycle_end),
      .rate       (rate)
   );

   qclk_phase_gen #(
      .SLOW_PER  (SLOW_PER),  .SLOW_HI  (SLOW_HI),  .SLOW_LEAD (SLOW_LEAD),
      .NORM_PER  (NORM_PER),  .NORM_HI  (NORM_HI),  .NORM_LEAD (NORM_LEAD),
      .TURBO_PER (TURBO_PER), .TURBO_HI (TURBO_HI), .TURBO_LEAD(TURBO_LEAD)
   ) i_phase_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rate     (rate),
      .cycle_end(cycle_end),
      .e_clk    (e_clk),
      .q_clk    (q_clk)
   );

   assign fast_ind  = fast_sel;
   assign turbo_ind = (rate == RATE_TURBO);

   // R8
   rate_at_e_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate) |-> $fell(e_clk));
   // R6
   turbo_needs_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(turbo_ind) |-> ($past(fast_sel) && $past(turbo_strap)));
   // R7
   no_turbo_when_grounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(e_clk) && !$past(turbo_strap)) |-> !turbo_ind);
endmodule

// File: tb/test_qclk_gen.sv
module test_qclk_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        wr = 1'b0;
   logic        turbo_strap = 1'b1;
   logic        e_clk, q_clk, fast_ind, turbo_ind;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   qclk_gen i_qclk_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr(wr),
      .turbo_strap(turbo_strap), .e_clk(e_clk), .q_clk(q_clk),
      .fast_ind(fast_ind), .turbo_ind(turbo_ind)
   );

   // bench timing tables: 0 slow, 1 normal, 2 turbo
   function automatic int per_of(int m);
      return (m == 2) ? 6 : (m == 1) ? 16 : 32;
   endfunction
   function automatic int hi_of(int m);
      return (m == 2) ? 3 : (m == 1) ? 8 : 16;
   endfunction
   function automatic int lead_of(int m);
      return (m == 2) ? 1 : (m == 1) ? 4 : 8;
   endfunction
   function automatic string tag_of(int m);
      return (m == 2) ? "R6" : (m == 1) ? "R5" : "R4";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // monitor model state
   bit p_tick, p_strap, p_wr;
   logic [15:0] p_addr;
   bit fast_m;
   int mode_m, tcnt;
   bit prev_e;

   initial begin : monitor
      wait (rst_n);
      @(negedge clk);
      // R1: reset state before the first active edge
      check(e_clk == 1'b0,     "R1", "e after reset",     e_clk, 0);
      check(q_clk == 1'b0,     "R1", "q after reset",     q_clk, 0);
      check(fast_ind == 1'b0,  "R1", "fast after reset",  fast_ind, 0);
      check(turbo_ind == 1'b0, "R1", "turbo after reset", turbo_ind, 0);
      fast_m = 1'b0; mode_m = 0; tcnt = 0; prev_e = 1'b0;
      p_tick = tick; p_strap = turbo_strap; p_wr = wr; p_addr = addr;
      forever begin
         @(negedge clk);
         if (done) break;
         begin
            bit fast_before, ok_e, ok_q;
            int exp_e, exp_q, pm, nm;
            string tg;
            fast_before = fast_m;
            if (p_wr && p_addr == 16'hFFD9) fast_m = 1'b1;
            else if (p_wr && p_addr == 16'hFFD8) fast_m = 1'b0;
            if (p_tick) begin
               tcnt++;
               if (tcnt == per_of(mode_m)) begin
                  tcnt = 0;
                  nm = !fast_before ? 0 : (p_strap ? 2 : 1);
                  mode_m = nm;
               end
            end
            pm = mode_m;
            exp_e = (tcnt >= per_of(pm) - hi_of(pm)) ? 1 : 0;
            exp_q = (tcnt >= per_of(pm) - hi_of(pm) - lead_of(pm) &&
                     tcnt <  per_of(pm) - lead_of(pm)) ? 1 : 0;
            tg = p_tick ? tag_of(pm) : "R9";
            ok_e = (e_clk == exp_e[0]);
            ok_q = (q_clk == exp_q[0]);
            check(ok_e, tg, "e level", e_clk, exp_e);
            check(ok_q, tg, "q level", q_clk, exp_q);
            // R10: Q is high whenever E has just risen
            if (e_clk && !prev_e) check(q_clk == 1'b1, "R10", "q at e rise", q_clk, 1);
            // R2 / R3: speed selection decoding
            check(fast_ind == fast_m, p_wr && p_addr == 16'hFFD9 ? "R2" : "R3",
                  "fast_ind", fast_ind, fast_m);
            // R8 (R7 when normal speed is selected with a grounded strap)
            check(turbo_ind == (pm == 2), (fast_before && !p_strap) ? "R7" : "R8",
                  "turbo_ind", turbo_ind, (pm == 2) ? 1 : 0);
            prev_e = e_clk;
         end
         p_tick = tick; p_strap = turbo_strap; p_wr = wr; p_addr = addr;
      end
   end

   task automatic step(input bit t, input bit w, input logic [15:0] a);
      @(posedge clk); #2;
      tick = t; wr = w; addr = a;
   endtask

   task automatic run_ticks(input int n, input int pct);
      for (int i = 0; i < n; i++) step(($urandom % 100) < pct, 1'b0, 16'h0000);
   endtask

   initial begin : stim
      void'($urandom(32'd1999));
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      run_ticks(100, 100);                 // R4 slow with continuous ticks
      step(1'b1, 1'b1, 16'hFF10);          // R3 other address ignored
      run_ticks(80, 60);
      step(1'b0, 1'b1, 16'hFFD9);          // R2 select normal, strap open -> turbo
      run_ticks(120, 100);                 // R6
      turbo_strap = 1'b0;                  // R7 strap grounded
      run_ticks(120, 80);
      step(1'b1, 1'b1, 16'hFFDA);          // R3 neighbour address ignored
      turbo_strap = 1'b1;
      run_ticks(60, 100);
      step(1'b1, 1'b1, 16'hFFD8);          // R3 back to slow
      run_ticks(150, 90);
      for (int i = 0; i < 30000; i++) begin
         int r;
         logic [15:0] a;
         r = $urandom % 1000;
         a = (r < 8) ? 16'hFFD9 : (r < 14) ? 16'hFFD8 : (r < 20) ? 16'($urandom) : 16'h0000;
         if (($urandom % 300) == 0) turbo_strap = ~turbo_strap;
         step(($urandom % 100) < 75, r < 20, a);
      end
      step(1'b0, 1'b0, 16'h0000);
      @(posedge clk);
      done = 1'b1;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      #1500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule